// File: doc/BRIEF.md
# Multi-Cycle Five-Step Instruction Sequencer

This block executes a small 32-bit load/store instruction set one instruction at a time. Each instruction passes through up to five steps: fetch, decode with register read, execute or address calculation, memory access or branch completion, and write-back. The datapath keeps its own instruction word, next-PC, two operand latches, a sign-extended immediate, an ALU result latch, a load data latch and a branch condition flag. It also holds a 32-entry register file.

A single synchronous memory port carries both instruction fetches and data accesses. The port uses word addresses, taken from byte-address bits [31:2], and returns read data one cycle after the address is presented. Instructions that do not write a register stop after the memory step and go straight back to fetch. The current step, the PC and a retirement strobe are brought out so that an environment can follow each instruction.

Instruction fields are described in a numbering where bit 0 is the most significant bit. Bit k in that numbering is vector bit 31-k of the word.

Top module: `mc_seq`

## Requirements
- R1: While rst_ni is low, step_o is 0, pc_o is 0, done_o is 0, mem_we_o is 0 and mem_addr_o is 0. After reset, execution starts with a fetch from address 0.
- R2: Opcode 000000 (vector [31:26]) selects a register-register operation on rs1 (vector [25:21]) and rs2 (vector [20:16]). The function field (vector [10:0]) selects the operation: 0x020 add, 0x022 subtract (rs1-rs2), 0x024 and, 0x025 or, 0x026 xor. The result goes to the register named by bits 16..20 (vector [15:11]).
- R3: Opcodes 0x08 add, 0x0C and, 0x0D or and 0x0E xor combine rs1 with the 16-bit immediate (vector [15:0]). The immediate is sign-extended from bit 16 (vector bit 15). The result goes to the register named by bits 11..15 (vector [20:16]).
- R4: Opcode 0x23 loads the memory word at byte address rs1 + sign-extended immediate into the register named by vector [20:16].
- R5: Opcode 0x2B stores the register named by vector [20:16] to word address (rs1 + sign-extended immediate)>>2. mem_we_o is high for exactly one cycle, in the memory step, and a later load returns the stored value.
- R6: Opcode 0x04 branches when rs1 is zero and opcode 0x05 branches when rs1 is nonzero. A taken branch sets the PC to the branch's PC + 4 + the sign-extended immediate. A branch that is not taken sets the PC to its PC + 4.
- R7: Opcode 0x02 sets the PC to the jump's PC + 4 + the 26-bit offset in vector [25:0], sign-extended.
- R8: Register 0 reads as zero, and any write to it has no effect.
- R9: ALU operations and loads take 5 cycles. Stores, branches, jumps, unknown opcodes and unknown function codes take 4 cycles. The last two groups in that list change nothing. done_o is high exactly in the last cycle of each instruction.
- R10: In the fetch step, mem_addr_o equals pc_o[31:2]. pc_o changes only at the clock edge that ends a cycle with done_o high. Instructions that do not branch or jump advance the PC by 4.
- R11: step_o encodes fetch=0, decode=1, execute=2, memory=3, write-back=4. The steps advance in that order. Write-back is entered only for instructions that write a register, and fetch always follows the last step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 30 | Word address for fetch or data access |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the address |
| step_o | output | 3 | Current step |
| pc_o | output | 32 | PC of the instruction in flight |
| done_o | output | 1 | High in the last cycle of each instruction |

## Verification
The bound checker watches the step order, the rule that writes occur only in the memory step of a finishing store, the fetch address, the PC holding steady between retirements, and the advance by 4 after write-back. These are checked on every clock. Results held in the register file, sign extension, the direction of each branch, the jump target and the ignored writes to register 0 can be seen only through the bench's program. That program stores registers to memory and follows the PC, and each store and each retirement is matched against an architectural model in the bench.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NREG = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_BRZ   = 6'h04;
  localparam logic [5:0] OPC_BRNZ  = 6'h05;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_XORI  = 6'h0E;
  localparam logic [5:0] OPC_LDW   = 6'h23;
  localparam logic [5:0] OPC_STW   = 6'h2B;

  localparam logic [10:0] FN_ADD = 11'h020;
  localparam logic [10:0] FN_SUB = 11'h022;
  localparam logic [10:0] FN_AND = 11'h024;
  localparam logic [10:0] FN_OR  = 11'h025;
  localparam logic [10:0] FN_XOR = 11'h026;

  typedef enum logic [2:0] {
    ST_IF  = 3'd0,
    ST_ID  = 3'd1,
    ST_EX  = 3'd2,
    ST_MEM = 3'd3,
    ST_WB  = 3'd4
  } step_e;

  typedef enum logic [2:0] {
    CL_ALU_R, CL_ALU_I, CL_LOAD, CL_STORE, CL_BRANCH, CL_JUMP, CL_NOP
  } cls_e;

  typedef enum logic [2:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR
  } alu_op_e;

  typedef struct packed {
    cls_e        cls;
    alu_op_e     op;
    logic [4:0]  rd;
    logic        br_on_zero;
    logic        wb;
  } ctrl_t;
endpackage

// File: rtl/mc_seq_decode.sv
module mc_seq_decode
  import mc_seq_pkg::*;
(
  input  logic [5:0]  opc_i,
  input  logic [10:0] func_i,
  input  logic [4:0]  rd_imm_i,
  input  logic [4:0]  rd_reg_i,
  output ctrl_t       ctrl_o
);
  always_comb begin
    ctrl_o            = '0;
    ctrl_o.cls        = CL_NOP;
    ctrl_o.op         = OP_ADD;
    ctrl_o.rd         = rd_imm_i;
    ctrl_o.br_on_zero = 1'b0;
    ctrl_o.wb         = 1'b0;
    unique case (opc_i)
      OPC_RTYPE: begin
        ctrl_o.rd = rd_reg_i;
        ctrl_o.wb = 1'b1;
        ctrl_o.cls = CL_ALU_R;
        unique case (func_i)
          FN_ADD:  ctrl_o.op = OP_ADD;
          FN_SUB:  ctrl_o.op = OP_SUB;
          FN_AND:  ctrl_o.op = OP_AND;
          FN_OR:   ctrl_o.op = OP_OR;
          FN_XOR:  ctrl_o.op = OP_XOR;
          default: begin
            ctrl_o.cls = CL_NOP;
            ctrl_o.wb  = 1'b0;
          end
        endcase
      end
      OPC_ADDI: begin ctrl_o.cls = CL_ALU_I; ctrl_o.op = OP_ADD; ctrl_o.wb = 1'b1; end
      OPC_ANDI: begin ctrl_o.cls = CL_ALU_I; ctrl_o.op = OP_AND; ctrl_o.wb = 1'b1; end
      OPC_ORI:  begin ctrl_o.cls = CL_ALU_I; ctrl_o.op = OP_OR;  ctrl_o.wb = 1'b1; end
      OPC_XORI: begin ctrl_o.cls = CL_ALU_I; ctrl_o.op = OP_XOR; ctrl_o.wb = 1'b1; end
      OPC_LDW:  begin ctrl_o.cls = CL_LOAD;  ctrl_o.wb = 1'b1; end
      OPC_STW:  ctrl_o.cls = CL_STORE;
      OPC_BRZ:  begin ctrl_o.cls = CL_BRANCH; ctrl_o.br_on_zero = 1'b1; end
      OPC_BRNZ: ctrl_o.cls = CL_BRANCH;
      OPC_JUMP: ctrl_o.cls = CL_JUMP;
      default:  ctrl_o.cls = CL_NOP;
    endcase
  end
endmodule

// File: rtl/mc_seq_alu.sv
module mc_seq_alu
  import mc_seq_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      OP_SUB:  y_o = a_i - b_i;
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/mc_seq_regfile.sv
module mc_seq_regfile #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [$clog2(N)-1:0] ra_i,
  input  logic [$clog2(N)-1:0] rb_i,
  output logic [W-1:0]         rdata_a_o,
  output logic [W-1:0]         rdata_b_o,
  input  logic                 we_i,
  input  logic [$clog2(N)-1:0] wa_i,
  input  logic [W-1:0]         wd_i
);
  localparam int unsigned AW = $clog2(N);

  logic [N-1:0][W-1:0] regs_w;

  for (genvar gi = 0; gi < N; gi++) begin : g_reg
    if (gi == 0) begin : g_zero
      assign regs_w[gi] = '0;
    end else begin : g_live
      logic [W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (we_i && wa_i == AW'(gi)) q <= wd_i;
      end
      assign regs_w[gi] = q;
    end
  end

  assign rdata_a_o = regs_w[ra_i];
  assign rdata_b_o = regs_w[rb_i];
endmodule

// File: rtl/mc_seq.sv
module mc_seq
  import mc_seq_pkg::*;
#(
  parameter int unsigned XW = XLEN,
  parameter int unsigned NR = NREG
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [XW-3:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [XW-1:0] mem_wdata_o,
  input  logic [XW-1:0] mem_rdata_i,
  output logic [2:0]    step_o,
  output logic [XW-1:0] pc_o,
  output logic          done_o
);
  localparam int unsigned RAW = $clog2(NR);

  step_e         step_q;
  logic [XW-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, alu_q, lmd_q;
  logic          cond_q;

  ctrl_t         ctrl;
  logic [XW-1:0] rf_a, rf_b, opa, opb, alu_y;
  alu_op_e       alu_op;
  logic          cond_d, last;
  logic          rf_we;
  logic [XW-1:0] rf_wd;

  mc_seq_decode u_dec (
    .opc_i    (ir_q[31:26]),
    .func_i   (ir_q[10:0]),
    .rd_imm_i (ir_q[20:16]),
    .rd_reg_i (ir_q[15:11]),
    .ctrl_o   (ctrl)
  );

  // register reads use the word arriving from memory during decode
  mc_seq_regfile #(.W(XW), .N(NR)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_i      (mem_rdata_i[25:21]),
    .rb_i      (mem_rdata_i[20:16]),
    .rdata_a_o (rf_a),
    .rdata_b_o (rf_b),
    .we_i      (rf_we),
    .wa_i      (RAW'(ctrl.rd)),
    .wd_i      (rf_wd)
  );

  always_comb begin
    opa    = a_q;
    opb    = b_q;
    alu_op = ctrl.op;
    unique case (ctrl.cls)
      CL_ALU_I:            opb = imm_q;
      CL_LOAD, CL_STORE:   begin opb = imm_q; alu_op = OP_ADD; end
      CL_BRANCH:           begin opa = npc_q; opb = imm_q; alu_op = OP_ADD; end
      CL_JUMP:             begin
        opa    = npc_q;
        opb    = {{(XW-26){ir_q[25]}}, ir_q[25:0]};
        alu_op = OP_ADD;
      end
      default: ;
    endcase
  end

  mc_seq_alu #(.W(XW)) u_alu (
    .a_i  (opa),
    .b_i  (opb),
    .op_i (alu_op),
    .y_o  (alu_y)
  );

  always_comb begin
    unique case (ctrl.cls)
      CL_BRANCH: cond_d = ctrl.br_on_zero ? (a_q == '0) : (a_q != '0);
      CL_JUMP:   cond_d = 1'b1;
      default:   cond_d = 1'b0;
    endcase
  end

  assign last  = (step_q == ST_WB) || (step_q == ST_MEM && !ctrl.wb);
  assign rf_we = (step_q == ST_WB) && ctrl.wb;
  assign rf_wd = (ctrl.cls == CL_LOAD) ? lmd_q : alu_q;

  // load address leaves in execute so the data lands in LMD at the memory step
  always_comb begin
    if (step_q == ST_EX && ctrl.cls == CL_LOAD)        mem_addr_o = alu_y[XW-1:2];
    else if (step_q == ST_MEM && ctrl.cls == CL_STORE) mem_addr_o = alu_q[XW-1:2];
    else                                               mem_addr_o = pc_q[XW-1:2];
  end

  assign mem_we_o    = (step_q == ST_MEM) && (ctrl.cls == CL_STORE);
  assign mem_wdata_o = b_q;
  assign step_o      = step_q;
  assign pc_o        = pc_q;
  assign done_o      = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IF;
      pc_q   <= '0;
      npc_q  <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      imm_q  <= '0;
      alu_q  <= '0;
      lmd_q  <= '0;
      cond_q <= 1'b0;
    end else begin
      unique case (step_q)
        ST_IF: begin
          npc_q  <= pc_q + XW'(4);
          step_q <= ST_ID;
        end
        ST_ID: begin
          ir_q   <= mem_rdata_i;
          a_q    <= rf_a;
          b_q    <= rf_b;
          imm_q  <= {{(XW-16){mem_rdata_i[15]}}, mem_rdata_i[15:0]};
          step_q <= ST_EX;
        end
        ST_EX: begin
          alu_q  <= alu_y;
          cond_q <= cond_d;
          step_q <= ST_MEM;
        end
        ST_MEM: begin
          lmd_q <= mem_rdata_i;
          if (ctrl.wb) begin
            step_q <= ST_WB;
          end else begin
            pc_q   <= cond_q ? alu_q : npc_q;
            step_q <= ST_IF;
          end
        end
        ST_WB: begin
          pc_q   <= npc_q;
          step_q <= ST_IF;
        end
        default: step_q <= ST_IF;
      endcase
    end
  end
endmodule

// File: rtl/mc_seq_chk.sv
module mc_seq_chk #(
  parameter int unsigned XW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [XW-3:0] mem_addr_o,
  input logic          mem_we_o,
  input logic [2:0]    step_o,
  input logic [XW-1:0] pc_o,
  input logic          done_o
);
  assert_step_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o <= 3'd4);

  assert_if_to_id_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o == 3'd0 |=> step_o == 3'd1);

  assert_id_to_ex_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o == 3'd1 |=> step_o == 3'd2);

  assert_ex_to_mem_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o == 3'd2 |=> step_o == 3'd3);

  assert_mem_open_to_wb_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == 3'd3 && !done_o) |=> step_o == 3'd4);

  assert_done_then_fetch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> step_o == 3'd0);

  assert_done_late_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (step_o == 3'd3 || step_o == 3'd4));

  assert_write_in_mem_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (step_o == 3'd3 && done_o));

  assert_single_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  assert_fetch_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o == 3'd0 |-> mem_addr_o == pc_o[XW-1:2]);

  assert_pc_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(pc_o));

  assert_pc_plus4_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && step_o == 3'd4) |=> pc_o == $past(pc_o) + XW'(4));
endmodule

bind mc_seq mc_seq_chk #(.XW(XW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_addr_o (mem_addr_o),
  .mem_we_o   (mem_we_o),
  .step_o     (step_o),
  .pc_o       (pc_o),
  .done_o     (done_o)
);

// File: tb/tb_mc_seq.sv
`timescale 1ns/1ps
module tb_mc_seq;
  localparam int MW = 256;

  localparam logic [5:0]  T_RT = 6'h00, T_J = 6'h02, T_BZ = 6'h04, T_BNZ = 6'h05;
  localparam logic [5:0]  T_ADDI = 6'h08, T_ANDI = 6'h0C, T_ORI = 6'h0D, T_XORI = 6'h0E;
  localparam logic [5:0]  T_LW = 6'h23, T_SW = 6'h2B;
  localparam logic [10:0] F_ADD = 11'h020, F_SUB = 11'h022, F_AND = 11'h024;
  localparam logic [10:0] F_OR = 11'h025, F_XOR = 11'h026;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [29:0] mem_addr;
  logic        mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [2:0]  step;
  logic [31:0] pc;
  logic        done;

  always #4 clk = ~clk;

  mc_seq dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .step_o      (step),
    .pc_o        (pc),
    .done_o      (done)
  );

  logic [31:0] mem     [MW];
  logic [31:0] ref_mem [MW];
  string       tag_mem [MW];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  typedef struct { logic [31:0] pc; int cyc; string tag; } ret_t;
  typedef struct { logic [29:0] addr; logic [31:0] data; string tag; } st_t;
  ret_t ret_q[$];
  st_t  st_q[$];

  int nchk = 0;
  int nerr = 0;
  int wp   = 0;
  bit run  = 0;
  bit mon_done = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [10:0] fn, int rd, int rs1, int rs2);
    return {T_RT, 5'(rs1), 5'(rs2), 5'(rd), fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rd, int rs1, logic [15:0] imm);
    return {op, 5'(rs1), 5'(rd), imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [25:0] off);
    return {T_J, off};
  endfunction

  // driver side: place one instruction, tagging stores with the requirement they prove
  task automatic put(logic [31:0] w, string t);
    mem[wp]     = w;
    tag_mem[wp] = t;
    wp++;
  endtask

  // architectural model: pushes expected retirements and stores
  task automatic run_ref();
    logic [31:0] rr[32];
    logic [31:0] rpc, w, imm, npc, nxt, val, ea;
    int cyc, dst;
    bit wr;
    string tg;
    for (int i = 0; i < 32; i++) rr[i] = '0;
    for (int i = 0; i < MW; i++) ref_mem[i] = mem[i];
    rpc = '0;
    for (int n = 0; n < 1000; n++) begin
      w   = ref_mem[rpc[9:2]];
      imm = {{16{w[15]}}, w[15:0]};
      npc = rpc + 32'd4;
      nxt = npc;
      cyc = 4; wr = 0; dst = 0; val = '0; tg = "R9";
      ea  = rr[w[25:21]] + imm;
      case (w[31:26])
        T_RT: begin
          dst = int'(w[15:11]); wr = 1; cyc = 5; tg = "R2";
          case (w[10:0])
            F_ADD: val = rr[w[25:21]] + rr[w[20:16]];
            F_SUB: val = rr[w[25:21]] - rr[w[20:16]];
            F_AND: val = rr[w[25:21]] & rr[w[20:16]];
            F_OR:  val = rr[w[25:21]] | rr[w[20:16]];
            F_XOR: val = rr[w[25:21]] ^ rr[w[20:16]];
            default: begin wr = 0; cyc = 4; tg = "R9"; end
          endcase
        end
        T_ADDI: begin wr = 1; cyc = 5; tg = "R3"; dst = int'(w[20:16]); val = rr[w[25:21]] + imm; end
        T_ANDI: begin wr = 1; cyc = 5; tg = "R3"; dst = int'(w[20:16]); val = rr[w[25:21]] & imm; end
        T_ORI:  begin wr = 1; cyc = 5; tg = "R3"; dst = int'(w[20:16]); val = rr[w[25:21]] | imm; end
        T_XORI: begin wr = 1; cyc = 5; tg = "R3"; dst = int'(w[20:16]); val = rr[w[25:21]] ^ imm; end
        T_LW:   begin wr = 1; cyc = 5; tg = "R4"; dst = int'(w[20:16]); val = ref_mem[ea[9:2]]; end
        T_SW: begin
          tg = "R5";
          st_q.push_back('{ea[31:2], rr[w[20:16]], tag_mem[rpc[9:2]]});
          ref_mem[ea[9:2]] = rr[w[20:16]];
        end
        T_BZ:  begin tg = "R6"; if (rr[w[25:21]] == '0) nxt = npc + imm; end
        T_BNZ: begin tg = "R6"; if (rr[w[25:21]] != '0) nxt = npc + imm; end
        T_J:   begin tg = "R7"; nxt = npc + {{6{w[25]}}, w[25:0]}; end
        default: ;
      endcase
      if (wr && dst != 0) rr[dst] = val;
      ret_q.push_back('{rpc, cyc, tg});
      if (nxt == rpc) break;
      rpc = nxt;
    end
  endtask

  task automatic build();
    for (int i = 0; i < MW; i++) begin mem[i] = '0; tag_mem[i] = ""; end
    mem[128] = 32'h1234_5678;
    mem[129] = 32'hFFFF_FFF0;
    put(enc_i(T_ADDI, 1, 0, 16'h0200), "");
    put(enc_i(T_ADDI, 2, 0, 16'hFFFB), "");
    put(enc_i(T_LW, 3, 1, 16'h0000), "");
    put(enc_i(T_LW, 4, 1, 16'h0004), "");
    put(enc_r(F_ADD, 5, 3, 4), "");
    put(enc_r(F_SUB, 6, 3, 2), "");
    put(enc_r(F_AND, 7, 3, 4), "");
    put(enc_r(F_OR,  8, 2, 3), "");
    put(enc_r(F_XOR, 9, 3, 4), "");
    put(enc_i(T_ANDI, 10, 3, 16'hFF00), "");
    put(enc_i(T_ORI, 11, 0, 16'h8001), "");
    put(enc_i(T_XORI, 12, 3, 16'h7FFF), "");
    put(enc_i(T_ADDI, 0, 3, 16'h0055), "");
    put(enc_r(F_ADD, 0, 3, 4), "");
    put({6'h3F, 5'd0, 5'd13, 16'h1234}, "");
    put(enc_r(11'h7FF, 14, 3, 4), "");
    put(enc_i(T_BZ, 0, 0, 16'h0008), "");
    put(enc_i(T_ADDI, 15, 0, 16'h0001), "");
    put(enc_i(T_ADDI, 15, 0, 16'h0002), "");
    put(enc_i(T_BNZ, 0, 0, 16'h0004), "");
    put(enc_i(T_ADDI, 16, 0, 16'h0003), "");
    put(enc_i(T_BZ, 0, 3, 16'h0004), "");
    put(enc_i(T_ADDI, 17, 0, 16'h0004), "");
    put(enc_j(26'h0000004), "");
    put(enc_i(T_ADDI, 18, 0, 16'h0009), "");
    put(enc_i(T_ADDI, 19, 19, 16'h0001), "");
    put(enc_i(T_ADDI, 20, 19, 16'hFFFD), "");
    put(enc_i(T_BNZ, 0, 20, 16'hFFF4), "");
    put(enc_i(T_SW, 1,  1, 16'h0008), "R3");
    put(enc_i(T_SW, 2,  1, 16'h000C), "R3");
    put(enc_i(T_SW, 3,  1, 16'h0010), "R4");
    put(enc_i(T_SW, 4,  1, 16'h0014), "R4");
    put(enc_i(T_SW, 5,  1, 16'h0018), "R2");
    put(enc_i(T_SW, 6,  1, 16'h001C), "R2");
    put(enc_i(T_SW, 7,  1, 16'h0020), "R2");
    put(enc_i(T_SW, 8,  1, 16'h0024), "R2");
    put(enc_i(T_SW, 9,  1, 16'h0028), "R2");
    put(enc_i(T_SW, 10, 1, 16'h002C), "R3");
    put(enc_i(T_SW, 11, 1, 16'h0030), "R3");
    put(enc_i(T_SW, 12, 1, 16'h0034), "R3");
    put(enc_i(T_SW, 0,  1, 16'h0038), "R8");
    put(enc_i(T_SW, 13, 1, 16'h003C), "R9");
    put(enc_i(T_SW, 14, 1, 16'h0040), "R9");
    put(enc_i(T_SW, 15, 1, 16'h0044), "R6");
    put(enc_i(T_SW, 16, 1, 16'h0048), "R6");
    put(enc_i(T_SW, 17, 1, 16'h004C), "R6");
    put(enc_i(T_SW, 18, 1, 16'h0050), "R7");
    put(enc_i(T_SW, 19, 1, 16'h0054), "R6");
    put(enc_i(T_SW, 20, 1, 16'h0058), "R6");
    put(enc_i(T_LW, 21, 1, 16'h0018), "");
    put(enc_i(T_SW, 21, 1, 16'h005C), "R5");
    put(enc_j(26'h3FFFFFC), "");
  endtask

  // monitor: compares outputs against the scoreboard queues
  initial begin
    logic [2:0] prev_step = '0;
    bit prev_done = 1'b1;
    int cnt = 0;
    ret_t r;
    st_t s;
    forever begin
      @(negedge clk);
      #1;
      if (run && !mon_done) begin
        chk(step == (prev_done ? 3'd0 : prev_step + 3'd1), "R11", "step order",
            32'(step), 32'(prev_done ? 3'd0 : prev_step + 3'd1));
        prev_step = step;
        prev_done = done;
        cnt = (step == 3'd0) ? 1 : cnt + 1;
        if (mem_we) begin
          if (st_q.size() == 0) begin
            chk(1'b0, "R5", "unexpected store", {2'b00, mem_addr}, '0);
          end else begin
            s = st_q.pop_front();
            chk(mem_addr == s.addr, s.tag, "store address", {2'b00, mem_addr}, {2'b00, s.addr});
            chk(mem_wdata == s.data, s.tag, "stored value", mem_wdata, s.data);
          end
        end
        if (done) begin
          if (ret_q.size() == 0) begin
            chk(1'b0, "R9", "unexpected retirement", pc, '0);
          end else begin
            r = ret_q.pop_front();
            chk(pc == r.pc, "R10", {"retire pc, class ", r.tag}, pc, r.pc);
            chk(cnt == r.cyc, "R9", {"cycles, class ", r.tag}, 32'(cnt), 32'(r.cyc));
            if (ret_q.size() == 0) mon_done = 1;
          end
        end
      end
    end
  end

  initial begin
    int wd;
    build();
    run_ref();
    repeat (3) @(negedge clk);
    #1;
    chk(step == 3'd0, "R1", "reset step", 32'(step), 0);
    chk(pc == '0, "R1", "reset pc", pc, 0);
    chk(done == 1'b0, "R1", "reset done", 32'(done), 0);
    chk(mem_we == 1'b0, "R1", "reset write strobe", 32'(mem_we), 0);
    chk(mem_addr == '0, "R1", "reset address", {2'b00, mem_addr}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    run    = 1'b1;
    wd = 0;
    while (!mon_done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!mon_done) chk(1'b0, "R9", "watchdog expired", 32'(wd), 20000);
    chk(st_q.size() == 0, "R5", "stores left unseen", 32'(st_q.size()), 0);
    run = 1'b0;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule